// File: doc/BRIEF.md
# Floating-Point Error Interrupt Latch

This block turns the CPU's active-low floating-point error line into a level interrupt request for an external interrupt controller. The CPU's internal exception path is not used. The request is steered onto one of sixteen controller channels chosen by a select input; software normally picks channel 13. The error line is asynchronous, so it passes through a two-stage synchronizer, and only its inactive-to-active edge arms the request.

The handler acknowledges the error by writing to one fixed I/O port, 0x00F0. That single write drops the request and also drives the CPU's active-low ignore-numeric-error output. With that output active, the handler can run floating-point instructions while it clears the fault. Once the handler has fixed the error condition, the CPU releases the error line, and the ignore output is then released.

There is no data stream here. Every pin is a plain control or status level or strobe, so there is no valid/ready pair and no back-pressure.

Top module: `fpu_err_irq`

## Requirements
- R1: While reset is asserted, and right after it is released, `irq_req` is 0, `ignne_n` is 1 and `irq_lines` is all zeros. Reset is asynchronous and active low.
- R2: A high-to-low change on `fpu_err_n` that is set up before a clock edge makes `irq_req` read 1 after the third rising edge. It still reads 0 after the second.
- R3: A raised request stays at 1 until a clearing write. It rises again only after `fpu_err_n` has returned high and then gone low again.
- R4: A clearing write is a cycle in which `io_wr` is 1 and `io_addr` equals 0x00F0 exactly. It drives `irq_req` to 0 at that clock edge. A write to any other address, or the matching address with `io_wr` at 0, has no effect.
- R5: The clearing write drives `ignne_n` to 0 at the same edge.
- R6: `ignne_n` returns to 1 on the third rising edge after `fpu_err_n` goes high. If the error line is already high when the clearing write lands, `ignne_n` returns to 1 on the edge after that write.
- R7: If the clearing write lands in the same cycle that a new error edge arms the request, the request stays at 1. `ignne_n` is still driven to 0.
- R8: `irq_lines[route_sel]` equals `irq_req` and every other bit of `irq_lines` is 0. A change of `route_sel` is reflected in the same cycle.
- R9: After a clearing write, an error line that stays low does not raise the request again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fpu_err_n | input | 1 | Floating-point error from the CPU, active low, asynchronous |
| io_wr | input | 1 | I/O write strobe, one cycle per write |
| io_addr | input | 16 | I/O port address of the write |
| route_sel | input | 4 | Controller channel that carries the request |
| irq_req | output | 1 | Pending floating-point error request |
| irq_lines | output | 16 | Request steered onto the selected channel |
| ignne_n | output | 1 | Ignore-numeric-error to the CPU, active low |

## Verification
- **Error edge to request:** the request appears after the third rising edge following an error edge. That is two synchronizer stages plus the request register.
- **Clearing write:** the write acts on `irq_req` and `ignne_n` at the very edge that samples it.
- **Release of the error line:** `ignne_n` rises three edges after the error line goes high.
- **Routing:** `irq_lines` follows `irq_req` and `route_sel` with no register in between.

The bench drives inputs at the falling edge and samples one nanosecond after each rising edge. The vector table therefore states the expected outputs for every single cycle, including the cycles just before each result becomes due. Those early cycles confirm that nothing shows up too soon.

// File: rtl/fpuerr_pkg.sv
package fpuerr_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned N_CHAN    = 16;
  localparam int unsigned SEL_W     = $clog2(N_CHAN);
  localparam int unsigned SYNC_LEN  = 2;
  localparam logic [ADDR_W-1:0] ACK_PORT = 16'h00F0;
endpackage

// File: rtl/fpuerr_sync.sv
module fpuerr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_n_async,
  output logic err_act,
  output logic err_rise
);
  logic [STAGES-1:0] chain;
  logic              act_q;

  // the chain resets to the inactive (high) level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], err_n_async};
  end

  assign err_act = ~chain[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= err_act;
  end

  assign err_rise = err_act & ~act_q;
endmodule

// File: rtl/fpuerr_decode.sv
module fpuerr_decode #(
  parameter int unsigned         ADDR_W = 16,
  parameter logic [ADDR_W-1:0]   PORT   = '0
) (
  input  logic              io_wr,
  input  logic [ADDR_W-1:0] io_addr,
  output logic              ack_hit
);
  assign ack_hit = io_wr && (io_addr == PORT);
endmodule

// File: rtl/fpuerr_core.sv
module fpuerr_core (
  input  logic clk,
  input  logic rst_n,
  input  logic err_act,
  input  logic err_rise,
  input  logic ack_hit,
  output logic req,
  output logic ign_on
);
  // a fresh error edge outranks an acknowledge in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        req <= 1'b0;
    else if (err_rise) req <= 1'b1;
    else if (ack_hit)  req <= 1'b0;
  end

  // held from the acknowledge until the synchronized error is seen inactive
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ign_on <= 1'b0;
    else if (ack_hit)  ign_on <= 1'b1;
    else if (!err_act) ign_on <= 1'b0;
  end
endmodule

// File: rtl/fpuerr_route.sv
module fpuerr_route #(
  parameter int unsigned N_CHAN = 16,
  parameter int unsigned SEL_W  = 4
) (
  input  logic             req,
  input  logic [SEL_W-1:0] sel,
  output logic [N_CHAN-1:0] lines
);
  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    assign lines[ch] = req && (sel == SEL_W'(ch));
  end
endmodule

// File: rtl/fpu_err_irq.sv
module fpu_err_irq
  import fpuerr_pkg::*;
#(
  parameter int unsigned       P_ADDR_W = ADDR_W,
  parameter int unsigned       P_N_CHAN = N_CHAN,
  parameter int unsigned       P_SYNC   = SYNC_LEN,
  parameter logic [P_ADDR_W-1:0] P_PORT = ACK_PORT
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fpu_err_n,
  input  logic                        io_wr,
  input  logic [P_ADDR_W-1:0]         io_addr,
  input  logic [$clog2(P_N_CHAN)-1:0] route_sel,
  output logic                        irq_req,
  output logic [P_N_CHAN-1:0]         irq_lines,
  output logic                        ignne_n
);
  localparam int unsigned L_SEL_W = $clog2(P_N_CHAN);

  logic err_act, err_rise, ack_hit, ign_on;

  fpuerr_sync #(.STAGES(P_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .err_n_async(fpu_err_n),
    .err_act(err_act), .err_rise(err_rise));

  fpuerr_decode #(.ADDR_W(P_ADDR_W), .PORT(P_PORT)) u_dec (
    .io_wr(io_wr), .io_addr(io_addr), .ack_hit(ack_hit));

  fpuerr_core u_core (
    .clk(clk), .rst_n(rst_n), .err_act(err_act), .err_rise(err_rise),
    .ack_hit(ack_hit), .req(irq_req), .ign_on(ign_on));

  fpuerr_route #(.N_CHAN(P_N_CHAN), .SEL_W(L_SEL_W)) u_route (
    .req(irq_req), .sel(route_sel), .lines(irq_lines));

  assign ignne_n = ~ign_on;
endmodule

// File: rtl/fpuerr_chk.sv
module fpuerr_chk #(
  parameter int unsigned         ADDR_W = 16,
  parameter int unsigned         N_CHAN = 16,
  parameter logic [ADDR_W-1:0]   PORT   = '0
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      io_wr,
  input logic [ADDR_W-1:0]         io_addr,
  input logic [$clog2(N_CHAN)-1:0] route_sel,
  input logic                      err_act,
  input logic                      err_rise,
  input logic                      irq_req,
  input logic [N_CHAN-1:0]         irq_lines,
  input logic                      ignne_n
);
  logic ack;
  assign ack = io_wr && (io_addr == PORT);

  // R2 / R7
  a_r2_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    err_rise |=> irq_req);
  // R4
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !err_rise) |=> !irq_req);
  // R3
  a_r3_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !ack) |=> irq_req);
  // R9
  a_r9_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_req && !err_rise) |=> !irq_req);
  // R5
  a_r5_ack_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ignne_n);
  // R6
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!ignne_n && !err_act && !ack) |=> ignne_n);
  // R8
  a_r8_route: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines) && (irq_lines[route_sel] == irq_req));
endmodule

bind fpu_err_irq fpuerr_chk #(.ADDR_W(P_ADDR_W), .N_CHAN(P_N_CHAN), .PORT(P_PORT)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
  .route_sel(route_sel), .err_act(err_act), .err_rise(err_rise),
  .irq_req(irq_req), .irq_lines(irq_lines), .ignne_n(ignne_n));

// File: tb/fpu_err_irq_test.sv
module fpu_err_irq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fpu_err_n = 1'b1;
  logic        io_wr = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  route_sel = 4'd13;
  logic        irq_req, ignne_n;
  logic [15:0] irq_lines;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  fpu_err_irq uut (
    .clk(clk), .rst_n(rst_n), .fpu_err_n(fpu_err_n), .io_wr(io_wr),
    .io_addr(io_addr), .route_sel(route_sel), .irq_req(irq_req),
    .irq_lines(irq_lines), .ignne_n(ignne_n));

  typedef struct packed {
    logic        err_n;
    logic        wr;
    logic [15:0] addr;
    logic [3:0]  sel;
    logic        req;
    logic        ign_n;
    logic [3:0]  tag;
  } vec_t;

  // one row per cycle; expectations sampled after that cycle's rising edge
  localparam vec_t TBL [16] = '{
    '{1'b0, 1'b0, 16'h0000, 4'd13, 1'b0, 1'b1, 4'd2},
    '{1'b0, 1'b0, 16'h0000, 4'd13, 1'b0, 1'b1, 4'd2},
    '{1'b0, 1'b0, 16'h0000, 4'd13, 1'b1, 1'b1, 4'd2},
    '{1'b0, 1'b1, 16'h00F1, 4'd13, 1'b1, 1'b1, 4'd4},
    '{1'b0, 1'b0, 16'h00F0, 4'd3,  1'b1, 1'b1, 4'd4},
    '{1'b0, 1'b1, 16'h00F0, 4'd3,  1'b0, 1'b0, 4'd5},
    '{1'b0, 1'b0, 16'h0000, 4'd3,  1'b0, 1'b0, 4'd9},
    '{1'b1, 1'b0, 16'h0000, 4'd7,  1'b0, 1'b0, 4'd6},
    '{1'b1, 1'b0, 16'h0000, 4'd7,  1'b0, 1'b0, 4'd6},
    '{1'b1, 1'b0, 16'h0000, 4'd7,  1'b0, 1'b1, 4'd6},
    '{1'b0, 1'b0, 16'h0000, 4'd0,  1'b0, 1'b1, 4'd3},
    '{1'b0, 1'b1, 16'h80F0, 4'd0,  1'b0, 1'b1, 4'd4},
    '{1'b0, 1'b0, 16'h0000, 4'd15, 1'b1, 1'b1, 4'd3},
    '{1'b1, 1'b1, 16'h00F0, 4'd15, 1'b0, 1'b0, 4'd5},
    '{1'b1, 1'b0, 16'h0000, 4'd15, 1'b0, 1'b0, 4'd6},
    '{1'b1, 1'b0, 16'h0000, 4'd15, 1'b0, 1'b1, 4'd6}
  };

  function automatic string rname(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic drive(input logic e, input logic w, input logic [15:0] a);
    @(negedge clk);
    fpu_err_n = e; io_wr = w; io_addr = a;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", "irq_req in reset", irq_req, 0);
    check("R1", "ignne_n in reset", ignne_n, 1);
    check("R1", "irq_lines in reset", irq_lines, 0);
    @(negedge clk) rst_n = 1'b1;
    tick();
    check("R1", "irq_req after reset", irq_req, 0);
    check("R1", "ignne_n after reset", ignne_n, 1);

    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      fpu_err_n = TBL[i].err_n; io_wr = TBL[i].wr;
      io_addr = TBL[i].addr; route_sel = TBL[i].sel;
      tick();
      check(rname(TBL[i].tag), $sformatf("row %0d irq_req", i), irq_req, TBL[i].req);
      check(rname(TBL[i].tag), $sformatf("row %0d ignne_n", i), ignne_n, TBL[i].ign_n);
      check("R8", $sformatf("row %0d irq_lines", i), irq_lines,
            TBL[i].req ? (32'h1 << TBL[i].sel) : 32'h0);
    end

    // R7: acknowledge in the same cycle the error edge arms the request
    drive(1'b0, 1'b0, 16'h0000); tick();
    check("R2", "no request after 1 edge", irq_req, 0);
    drive(1'b0, 1'b0, 16'h0000); tick();
    drive(1'b0, 1'b1, 16'h00F0); tick();
    check("R7", "set wins over ack", irq_req, 1);
    check("R7", "ignne_n on coinciding ack", ignne_n, 0);
    drive(1'b0, 1'b0, 16'h0000); tick();
    check("R6", "ignne_n held while error low", ignne_n, 0);
    drive(1'b1, 1'b0, 16'h0000); tick(); tick();
    check("R6", "ignne_n before release", ignne_n, 0);
    tick();
    check("R6", "ignne_n released", ignne_n, 1);
    check("R3", "request kept without ack", irq_req, 1);

    // R8: steering follows route_sel in the same cycle
    @(negedge clk) route_sel = 4'd0; #1;
    check("R8", "lines with sel 0", irq_lines, 32'h0001);
    route_sel = 4'd13; #1;
    check("R8", "lines with sel 13", irq_lines, 32'h2000);

    // R6: ack while the error is already inactive
    drive(1'b1, 1'b1, 16'h00F0); tick();
    check("R4", "ack clears", irq_req, 0);
    check("R5", "ignne_n pulses on ack", ignne_n, 0);
    drive(1'b1, 1'b0, 16'h0000); tick();
    check("R6", "ignne_n released next edge", ignne_n, 1);

    // R1: reset in the middle of an active request
    drive(1'b0, 1'b0, 16'h0000); tick(); tick(); tick();
    check("R2", "request before reset", irq_req, 1);
    @(negedge clk) rst_n = 1'b0; #1;
    check("R1", "async reset clears request", irq_req, 0);
    check("R1", "async reset lines", irq_lines, 0);
    check("R1", "async reset ignne_n", ignne_n, 1);
    fpu_err_n = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule